// File: doc/BRIEF.md
# Preloaded PWM Timer With Trigger-Started Single Pulse

The block is an up-counting timer that drives one PWM pin. A prescaler divides the clock into count ticks. The counter steps from zero up to a reload limit and then wraps to zero. The pin is in its active state while the count is below a compare value. The pin's idle level is programmable. A simple synchronous register port carries all configuration. Writes take effect at the clock edge, and reads are combinational.

The reload and compare values can each be buffered. With buffering on, a value written while the timer runs is held and only becomes active at the next update event. An update event is either a counter wrap or an update forced by software. A forced update also restarts both the counter and the prescaler. It also loads the prescaler divisor, which is always buffered.

In single-pulse mode an armed timer waits for the chosen edge on a trigger input. It then runs exactly one period and stops itself. The timer keeps two sticky flags, one for update events and one for compare matches. Software clears a flag by writing a one to its bit.

Top module: `pwm_timer`

## Requirements
- R1: After reset, every register reads zero except the reload limit (address 4), which reads all ones. Both flags are low and `pwm_o` is low. The event register (address 1) always reads zero.
- R2: The prescaler register (address 3) holds P and the reload register holds A. After a forced update and a start, each period lasts (P+1)*(A+1) clocks. With polarity 0, `pwm_o` is high for (P+1)*C clocks of each period, where C is the compare value (address 6) and 0 < C <= A.
- R3: A compare value of 0 keeps the pin inactive for the whole period. A compare value above A keeps it active for the whole period.
- R4: Bit 0 of the channel register (address 5) inverts the pin. A stopped or waiting timer drives the pin to the level of that bit.
- R5: Writing 1 to bit 0 of address 1 forces an update. The update zeroes the counter and the prescaler, loads every buffered value, and sets the update flag, so the first period after it is full length.
- R6: The status register is at address 2, with the update flag in bit 0 and the compare flag in bit 1. Writing a one clears the matching flag. A zero leaves it unchanged, and 0x0F clears both.
- R7: Control bit 1 (address 0) enables reload buffering. When it is set, a reload value written while the timer runs takes effect only at the next update event. When it is clear, the value takes effect on the following clock.
- R8: Channel bit 1 enables compare buffering, with the same hold-until-update rule as R7.
- R9: The compare flag is set when a count tick moves the counter onto the active compare value, which includes a wrap onto a compare value of 0.
- R10: Control bit 2 selects single-pulse mode, and control bit 3 picks the falling trigger edge instead of the rising one. Once armed by control bit 0, the timer ignores the other edge. On the chosen edge it runs one full period, then clears control bit 0 and idles.
- R11: Writing 0 to the control register stops counting. The pin then goes idle and no further update events occur.
- R12: A counter wrap from the reload limit back to 0 sets the update flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for `addr_i` |
| trig_i | input | 1 | External trigger for single-pulse mode |
| pwm_o | output | 1 | PWM output |
| upd_flag_o | output | 1 | Sticky update flag |
| cmp_flag_o | output | 1 | Sticky compare flag |

## Verification
The bench builds the timer with an 8-bit counter and a 4-bit prescaler. This keeps every period to a few dozen clocks, so a sweep can cover prescaler values 0 to 2, reload limits 1, 2 and 4, every compare value from 0 to two above the limit, and both polarities. For each case, the expected high time over two periods is computed arithmetically. The buffered and unbuffered reload and compare paths, and both trigger edges of single-pulse mode, are timed from a known start edge, so the exact clock of each change is predicted in closed form.

// File: rtl/ptm_pkg.sv
package ptm_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL   = 3'd0,
    A_EVGEN  = 3'd1,
    A_STAT   = 3'd2,
    A_PSC    = 3'd3,
    A_RELOAD = 3'd4,
    A_CHAN   = 3'd5,
    A_CMP    = 3'd6
  } reg_addr_e;

  // packed: last field is bit 0
  typedef struct packed {
    logic trig_fall;
    logic one_shot;
    logic arr_buf;
    logic run;
  } ctrl_t;

  typedef struct packed {
    logic cmp_buf;
    logic pol;
  } chan_t;
endpackage

// File: rtl/ptm_regs.sv
module ptm_regs
  import ptm_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned PSC_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              upd_hw_i,
  input  logic              cmp_hit_i,
  input  logic              os_done_i,
  output ctrl_t             ctrl_o,
  output chan_t             chan_o,
  output logic [PSC_W-1:0]  psc_o,
  output logic [CNT_W-1:0]  arr_o,
  output logic [CNT_W-1:0]  cmp_o,
  output logic              ug_o,
  output logic              upd_flag_o,
  output logic              cmp_flag_o
);
  ctrl_t            ctrl_q;
  chan_t            chan_q;
  logic [PSC_W-1:0] psc_q;
  logic [CNT_W-1:0] arr_q, cmp_q;
  logic             upd_f_q, cmp_f_q;
  logic             wr_ctrl, wr_stat, wr_psc, wr_arr, wr_chan, wr_cmp;

  always_comb begin
    wr_ctrl = wr_en_i && (addr_i == A_CTRL);
    wr_stat = wr_en_i && (addr_i == A_STAT);
    wr_psc  = wr_en_i && (addr_i == A_PSC);
    wr_arr  = wr_en_i && (addr_i == A_RELOAD);
    wr_chan = wr_en_i && (addr_i == A_CHAN);
    wr_cmp  = wr_en_i && (addr_i == A_CMP);
    ug_o    = wr_en_i && (addr_i == A_EVGEN) && wdata_i[0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      chan_q  <= '0;
      psc_q   <= '0;
      arr_q   <= '1;
      cmp_q   <= '0;
      upd_f_q <= 1'b0;
      cmp_f_q <= 1'b0;
    end else begin
      if (wr_ctrl)        ctrl_q     <= ctrl_t'(wdata_i[3:0]);
      else if (os_done_i) ctrl_q.run <= 1'b0;
      if (wr_chan) chan_q <= chan_t'(wdata_i[1:0]);
      if (wr_psc)  psc_q  <= wdata_i[PSC_W-1:0];
      if (wr_arr)  arr_q  <= wdata_i[CNT_W-1:0];
      if (wr_cmp)  cmp_q  <= wdata_i[CNT_W-1:0];
      // set beats clear
      upd_f_q <= upd_hw_i || ug_o || (upd_f_q && !(wr_stat && wdata_i[0]));
      cmp_f_q <= cmp_hit_i || (cmp_f_q && !(wr_stat && wdata_i[1]));
    end
  end

  always_comb begin
    rdata_o = '0;
    case (reg_addr_e'(addr_i))
      A_CTRL:   rdata_o = DATA_W'(ctrl_q);
      A_STAT:   rdata_o = DATA_W'({cmp_f_q, upd_f_q});
      A_PSC:    rdata_o = DATA_W'(psc_q);
      A_RELOAD: rdata_o = DATA_W'(arr_q);
      A_CHAN:   rdata_o = DATA_W'(chan_q);
      A_CMP:    rdata_o = DATA_W'(cmp_q);
      default:  rdata_o = '0;
    endcase
  end

  assign ctrl_o     = ctrl_q;
  assign chan_o     = chan_q;
  assign psc_o      = psc_q;
  assign arr_o      = arr_q;
  assign cmp_o      = cmp_q;
  assign upd_flag_o = upd_f_q;
  assign cmp_flag_o = cmp_f_q;

  // R6
  w1c_upd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stat && wdata_i[0] && !upd_hw_i && !ug_o) |=> !upd_f_q);

  // R10
  os_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (os_done_i && !wr_ctrl) |=> !ctrl_q.run);

  // R12
  wrap_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_hw_i |=> upd_f_q);
endmodule

// File: rtl/ptm_shadow.sv
module ptm_shadow #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned PSC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             upd_i,
  input  logic             arr_buf_i,
  input  logic             cmp_buf_i,
  input  logic [CNT_W-1:0] arr_pre_i,
  input  logic [CNT_W-1:0] cmp_pre_i,
  input  logic [PSC_W-1:0] psc_pre_i,
  output logic [CNT_W-1:0] arr_act_o,
  output logic [CNT_W-1:0] cmp_act_o,
  output logic [PSC_W-1:0] psc_act_o
);
  localparam int unsigned N_SH = 2;  // 0: reload, 1: compare

  logic [CNT_W-1:0] pre [N_SH];
  logic [CNT_W-1:0] act_q [N_SH];
  logic [N_SH-1:0]  buf_en;
  logic [PSC_W-1:0] psc_q;

  assign pre[0] = arr_pre_i;
  assign pre[1] = cmp_pre_i;
  assign buf_en = {cmp_buf_i, arr_buf_i};

  for (genvar g = 0; g < N_SH; g++) begin : g_sh
    localparam logic [CNT_W-1:0] RST_V = (g == 0) ? {CNT_W{1'b1}} : {CNT_W{1'b0}};

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                   act_q[g] <= RST_V;
      else if (upd_i || !buf_en[g])  act_q[g] <= pre[g];
    end

    // R7, R8
    shadow_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (buf_en[g] && !upd_i) |=> $stable(act_q[g]));
  end

  // divisor is always buffered
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    psc_q <= '0;
    else if (upd_i) psc_q <= psc_pre_i;
  end

  assign arr_act_o = act_q[0];
  assign cmp_act_o = act_q[1];
  assign psc_act_o = psc_q;
endmodule

// File: rtl/ptm_core.sv
module ptm_core #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned PSC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             one_shot_i,
  input  logic             trig_fall_i,
  input  logic             pol_i,
  input  logic             trig_i,
  input  logic             ug_i,
  input  logic [CNT_W-1:0] arr_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic [PSC_W-1:0] psc_i,
  output logic             upd_hw_o,
  output logic             cmp_hit_o,
  output logic             os_done_o,
  output logic             pwm_o
);
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic [PSC_W-1:0] psc_cnt_q;
  logic             trig_q, trig_seen_q;
  logic             counting, trig_edge, tick, wrap, active;

  always_comb begin
    counting  = run_i && (!one_shot_i || trig_seen_q);
    trig_edge = trig_fall_i ? (trig_q && !trig_i) : (!trig_q && trig_i);
    tick      = counting && (psc_cnt_q >= psc_i);
    wrap      = tick && (cnt_q >= arr_i);  // >= survives an unbuffered lower limit
    cnt_nxt   = wrap ? '0 : cnt_q + CNT_W'(1);
    upd_hw_o  = wrap && !ug_i;
    cmp_hit_o = tick && !ug_i && (cnt_nxt == cmp_i);
    os_done_o = upd_hw_o && one_shot_i;
    active    = counting && (cnt_q < cmp_i);
    pwm_o     = active ^ pol_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q       <= '0;
      psc_cnt_q   <= '0;
      trig_q      <= 1'b0;
      trig_seen_q <= 1'b0;
    end else begin
      trig_q <= trig_i;
      if (ug_i) begin
        cnt_q     <= '0;
        psc_cnt_q <= '0;
      end else if (counting) begin
        psc_cnt_q <= tick ? '0 : psc_cnt_q + PSC_W'(1);
        if (tick) cnt_q <= cnt_nxt;
      end else begin
        psc_cnt_q <= '0;
      end
      if (!run_i || !one_shot_i || os_done_o) trig_seen_q <= 1'b0;
      else if (trig_edge)                     trig_seen_q <= 1'b1;
    end
  end

  // R5
  ug_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ug_i |=> (cnt_q == '0) && (psc_cnt_q == '0));

  // R11
  halt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!counting && !ug_i) |=> $stable(cnt_q));

  // R3
  cmp_zero_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_i == '0) |-> (pwm_o == pol_i));

  // R4
  idle_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !counting |-> (pwm_o == pol_i));
endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
  import ptm_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned PSC_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [2:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              trig_i,
  output logic              pwm_o,
  output logic              upd_flag_o,
  output logic              cmp_flag_o
);
  ctrl_t            ctrl;
  chan_t            chan;
  logic [PSC_W-1:0] psc_pre, psc_act;
  logic [CNT_W-1:0] arr_pre, cmp_pre, arr_act, cmp_act;
  logic             ug, upd_hw, cmp_hit, os_done;

  ptm_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .PSC_W(PSC_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .rdata_o    (rdata_o),
    .upd_hw_i   (upd_hw),
    .cmp_hit_i  (cmp_hit),
    .os_done_i  (os_done),
    .ctrl_o     (ctrl),
    .chan_o     (chan),
    .psc_o      (psc_pre),
    .arr_o      (arr_pre),
    .cmp_o      (cmp_pre),
    .ug_o       (ug),
    .upd_flag_o (upd_flag_o),
    .cmp_flag_o (cmp_flag_o)
  );

  ptm_shadow #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_shadow (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .upd_i     (ug || upd_hw),
    .arr_buf_i (ctrl.arr_buf),
    .cmp_buf_i (chan.cmp_buf),
    .arr_pre_i (arr_pre),
    .cmp_pre_i (cmp_pre),
    .psc_pre_i (psc_pre),
    .arr_act_o (arr_act),
    .cmp_act_o (cmp_act),
    .psc_act_o (psc_act)
  );

  ptm_core #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (ctrl.run),
    .one_shot_i  (ctrl.one_shot),
    .trig_fall_i (ctrl.trig_fall),
    .pol_i       (chan.pol),
    .trig_i      (trig_i),
    .ug_i        (ug),
    .arr_i       (arr_act),
    .cmp_i       (cmp_act),
    .psc_i       (psc_act),
    .upd_hw_o    (upd_hw),
    .cmp_hit_o   (cmp_hit),
    .os_done_o   (os_done),
    .pwm_o       (pwm_o)
  );
endmodule

// File: tb/pwm_timer_bench.sv
`timescale 1ns/1ps
module pwm_timer_bench;
  localparam int DATA_W = 16;
  localparam int CNT_W  = 8;
  localparam int PSC_W  = 4;
  localparam int WDOG   = 150000;

  localparam logic [2:0] A_CTRL = 3'd0, A_EVG = 3'd1, A_STAT = 3'd2, A_PSC = 3'd3,
                         A_REL = 3'd4, A_CHAN = 3'd5, A_CMP = 3'd6;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              wr_en_i = 1'b0;
  logic [2:0]        addr_i = '0;
  logic [DATA_W-1:0] wdata_i = '0;
  logic [DATA_W-1:0] rdata_o;
  logic              trig_i = 1'b0;
  logic              pwm_o, upd_flag_o, cmp_flag_o;

  int n_chk = 0, n_fail = 0, cyc = 0, hi_cnt = 0;
  bit meas = 1'b0, done = 1'b0;

  pwm_timer #(.DATA_W(DATA_W), .CNT_W(CNT_W), .PSC_W(PSC_W)) u_pwm_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .trig_i(trig_i), .pwm_o(pwm_o),
    .upd_flag_o(upd_flag_o), .cmp_flag_o(cmp_flag_o));

  always #10 clk_i = ~clk_i;
  always @(posedge clk_i) cyc++;
  always @(negedge clk_i) begin
    #1;
    if (meas && pwm_o) hi_cnt++;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input int d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = DATA_W'(d);
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int d);
    @(negedge clk_i);
    addr_i = a;
    #1 d = int'(rdata_o);
  endtask

  task automatic setup(input int p, input int a, input int c, input int chan);
    wr(A_CTRL, 0); wr(A_PSC, p); wr(A_REL, a); wr(A_CHAN, chan); wr(A_CMP, c);
    wr(A_EVG, 1); wr(A_STAT, 15);
  endtask

  task automatic measure(input int n);
    hi_cnt = 0; meas = 1'b1;
    repeat (n) @(negedge clk_i);
    meas = 1'b0;
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    int d, s, t, per, on, expv;
    int alist [3] = '{1, 2, 4};
    string tag;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;

    // R1 reset state
    rd(A_CTRL, d);  chk("R1", d, 0);
    rd(A_STAT, d);  chk("R1", d, 0);
    rd(A_REL, d);   chk("R1", d, 255);
    rd(A_CMP, d);   chk("R1", d, 0);
    rd(A_PSC, d);   chk("R1", d, 0);
    rd(A_EVG, d);   chk("R1", d, 0);
    chk("R1", pwm_o, 0);

    // R2 R3 R4 R9 R12 sweep
    for (int p = 0; p < 3; p++)
      for (int ai = 0; ai < 3; ai++)
        for (int c = 0; c <= alist[ai] + 2; c++)
          for (int pol = 0; pol < 2; pol++) begin
            setup(p, alist[ai], c, pol);
            wr(A_CTRL, 1);
            per = (p + 1) * (alist[ai] + 1);
            on  = 2 * (p + 1) * ((c < alist[ai] + 1) ? c : alist[ai] + 1);
            measure(2 * per);
            expv = pol ? 2 * per - on : on;
            tag = pol ? "R4" : ((c == 0 || c > alist[ai]) ? "R3" : "R2");
            chk(tag, hi_cnt, expv);
            chk("R12", upd_flag_o, 1);
            chk("R9", cmp_flag_o, (c <= alist[ai]) ? 1 : 0);
          end
    wr(A_CTRL, 0);
    chk("R4", pwm_o, 1);  // idle level follows polarity 1

    // R6 write-one-to-clear
    setup(0, 3, 1, 0);
    wr(A_CTRL, 1);
    repeat (10) @(negedge clk_i);
    wr(A_CTRL, 0);
    rd(A_STAT, d); chk("R6", d, 3);
    wr(A_STAT, 1); rd(A_STAT, d); chk("R6", d, 2);
    wr(A_STAT, 0); rd(A_STAT, d); chk("R6", d, 2);
    wr(A_STAT, 2); rd(A_STAT, d); chk("R6", d, 0);

    // R5 forced update sets flag while stopped
    wr(A_EVG, 1); rd(A_STAT, d); chk("R5", d, 1);
    rd(A_EVG, d); chk("R5", d, 0);

    // R11 stop
    setup(0, 3, 4, 0);
    wr(A_CTRL, 1);
    repeat (5) @(negedge clk_i);
    wr(A_CTRL, 0);
    wr(A_STAT, 15);
    measure(12);
    chk("R11", hi_cnt, 0);
    chk("R11", upd_flag_o, 0);

    // R7 buffered reload: old limit finishes, then period 4
    setup(0, 7, 2, 0);
    wr(A_CTRL, 3); s = cyc;
    wr(A_REL, 3);
    while (!upd_flag_o) @(negedge clk_i);
    chk("R7", cyc - s, 8);
    wr(A_STAT, 1);
    while (!upd_flag_o) @(negedge clk_i);
    chk("R7", cyc - s, 12);
    // R7 unbuffered reload: wraps as soon as count reaches 3
    setup(0, 7, 2, 0);
    wr(A_CTRL, 1); s = cyc;
    wr(A_REL, 3);
    while (!upd_flag_o) @(negedge clk_i);
    chk("R7", cyc - s, 4);
    wr(A_STAT, 1);
    while (!upd_flag_o) @(negedge clk_i);
    chk("R7", cyc - s, 8);

    // R8 buffered compare: 6 then 2 high clocks
    setup(0, 7, 6, 2);
    wr(A_CTRL, 1);
    hi_cnt = 0; meas = 1'b1;
    wr(A_CMP, 2);
    repeat (14) @(negedge clk_i);
    meas = 1'b0;
    chk("R8", hi_cnt, 8);
    // R8 unbuffered compare: 3 then 2
    setup(0, 7, 6, 0);
    wr(A_CTRL, 1);
    hi_cnt = 0; meas = 1'b1;
    wr(A_CMP, 2);
    repeat (14) @(negedge clk_i);
    meas = 1'b0;
    chk("R8", hi_cnt, 5);

    // R10 single pulse, rising edge
    trig_i = 1'b0;
    setup(1, 5, 3, 0);
    wr(A_CTRL, 5);
    measure(10);
    chk("R10", hi_cnt, 0);
    chk("R10", upd_flag_o, 0);
    trig_i = 1'b1;
    measure(30);
    chk("R10", hi_cnt, 6);
    chk("R10", upd_flag_o, 1);
    rd(A_CTRL, d); chk("R10", d, 4);
    hi_cnt = 0; meas = 1'b1;
    trig_i = 1'b0; repeat (3) @(negedge clk_i);
    trig_i = 1'b1; repeat (7) @(negedge clk_i);
    meas = 1'b0;
    chk("R10", hi_cnt, 0);

    // R10 single pulse, falling edge; rising edge ignored
    trig_i = 1'b0;
    setup(1, 5, 3, 0);
    wr(A_CTRL, 13);
    trig_i = 1'b1;
    measure(8);
    chk("R10", hi_cnt, 0);
    trig_i = 1'b0;
    measure(30);
    chk("R10", hi_cnt, 6);
    rd(A_CTRL, d); chk("R10", d, 12);

    t = cyc;
    done = 1'b1;
    summary();
  end

  initial begin
    wait (cyc >= WDOG);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R2 watchdog actual=%0d expected<%0d", cyc, WDOG);
      summary();
    end
  end
endmodule